// File: doc/BRIEF.md
# Helical symbol interleaver

This block reorders a stream of symbol vectors. On every transfer it takes one vector of COLS·GRP symbols and returns one vector of the same size. The input vector is cut into COLS runs of GRP adjacent symbols, and run j feeds column j of a conceptual array that grows without bound in rows. Each column sits STEP rows lower than the column to its left. Every transfer then reads out the next GRP rows of that array, one complete row after another.

Seen per column, the structure is simple. Column c carries a symbol stream that is delayed by c·STEP symbol slots. Column 0 passes straight through. Array cells that have not yet received a symbol read as the parameter INIT. Both sides use a valid/ready handshake. The output vector belongs to the input vector presented in the same cycle, so the block adds no pipeline latency. A synchronous reset loads INIT back into all stored cells.

Top module: `helical_interleaver`

## Requirements
- R1: `out_valid` always equals `in_valid` and `in_ready` always equals `out_ready`. A vector is transferred in a cycle where `in_valid` and `out_ready` are both high.
- R2: Input symbol k sits at `in_data[k*W +: W]`. Symbols j·GRP through j·GRP+GRP-1 make up group j, and group j feeds column j.
- R3: Output symbol r·COLS+c sits at `out_data[(r*COLS+c)*W +: W]`. It holds row r (0..GRP-1) of column c for the current transfer.
- R4: Across transferred vectors, column c emits its input stream delayed by exactly c·STEP symbol slots.
- R5: Column 0 has no delay. Output symbols r·COLS equal input symbols r of the same cycle.
- R6: An array position that no symbol has reached yet is output as INIT.
- R7: A cycle without a transfer changes no stored symbol. The output sequence depends only on the transferred vectors, whatever the idle cycles or stall cycles between them.
- R8: Synchronous reset (`rst` high at a clock edge) returns all storage to INIT. After reset the block behaves as after power-up.
- R9: Take COLS=3, GRP=2, STEP=1, INIT=-1 (8'hFF), with inputs 1..6, 7..12 and 13..18 in symbol order. The outputs in symbol order are then [1,-1,-1,2,3,-1], [7,4,5,8,9,6] and [13,10,11,14,15,12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Input vector can be taken |
| in_data | input | COLS*GRP*W | Input symbol vector |
| out_valid | output | 1 | Output vector present |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | COLS*GRP*W | Interleaved symbol vector |

## Verification
A wrong stored symbol in column c shows up in that column's output lanes. It appears on the next transfer when c·STEP ≤ GRP, and otherwise within ceil(c·STEP/GRP) transfers. A misplaced pointer or shift shows up as a symbol in the wrong slot, or as a stale INIT, within the same bound. A stall that corrupts storage shows up on the first transfer after the stall ends. The bench compares each presented vector against a queue model, so every such fault is caught at the first transfer that exposes it.

// File: rtl/helical_interleaver.sv
module helical_interleaver #(
  parameter int COLS = 3,
  parameter int GRP  = 2,
  parameter int STEP = 1,
  parameter int W    = 8,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [COLS*GRP*W-1:0]  in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [COLS*GRP*W-1:0]  out_data
);
  logic accept;
  logic was_acc;
  logic fresh;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign accept    = in_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_acc <= 1'b0;
      fresh   <= 1'b1;
    end else begin
      was_acc <= accept;
      if (accept) fresh <= 1'b0;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int D = c * STEP;
    if (D == 0) begin : g_pass
      for (genvar i = 0; i < GRP; i++) begin : g_sym
        assign out_data[(i*COLS+c)*W +: W] = in_data[(c*GRP+i)*W +: W];
      end
    end else begin : g_dly
      logic [D-1:0][W-1:0] hist;
      logic [D-1:0][W-1:0] hist_nx;

      for (genvar i = 0; i < GRP; i++) begin : g_out
        if (i < D) begin : g_old
          assign out_data[(i*COLS+c)*W +: W] = hist[i];
        end else begin : g_new
          assign out_data[(i*COLS+c)*W +: W] = in_data[(c*GRP+i-D)*W +: W];
        end
      end

      for (genvar j = 0; j < D; j++) begin : g_nx
        if (GRP + j < D) begin : g_keep
          assign hist_nx[j] = hist[GRP+j];
        end else begin : g_load
          assign hist_nx[j] = in_data[(c*GRP+GRP+j-D)*W +: W];
        end
      end

      always_ff @(posedge clk) begin
        if (rst)         hist <= {D{INIT}};
        else if (accept) hist <= hist_nx;
      end

      // R7
      stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(hist));

      // R6
      fresh_init_chk: assert property (@(posedge clk) disable iff (rst)
        (fresh && in_valid) |-> out_data[c*W +: W] == INIT);

      // R4
      newest_store_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> hist[D-1] == $past(in_data[(c*GRP+GRP-1)*W +: W]));

      if (D <= GRP) begin : g_short
        // R4
        carry_over_chk: assert property (@(posedge clk) disable iff (rst)
          (accept && was_acc) |-> out_data[c*W +: W] == $past(in_data[(c*GRP+GRP-D)*W +: W]));
      end
    end
  end
endmodule

// File: tb/sim_helical_interleaver.sv
module sim_helical_interleaver;
  localparam int CP = 10;
  localparam int C = 3;
  localparam int N = 2;
  localparam int S = 1;
  localparam int W = 8;
  localparam logic [W-1:0] INIT = 8'hFF;
  localparam int VB = C*N*W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [VB-1:0] din = '0;
  logic in_ready, out_valid;
  logic [VB-1:0] dout;

  int total = 0;
  int bad = 0;
  logic [W-1:0] q [C][$];

  always #(CP/2) clk = ~clk;

  helical_interleaver #(.COLS(C), .GRP(N), .STEP(S), .W(W), .INIT(INIT)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(din),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(dout));

  function automatic void model_reset();
    for (int c = 0; c < C; c++) begin
      q[c].delete();
      for (int k = 0; k < c*S; k++) q[c].push_back(INIT);
    end
  endfunction

  function automatic logic [VB-1:0] model_out(input logic [VB-1:0] v);
    logic [VB-1:0] r = '0;
    for (int c = 0; c < C; c++)
      for (int i = 0; i < N; i++) begin
        if (i < q[c].size()) r[(i*C+c)*W +: W] = q[c][i];
        else r[(i*C+c)*W +: W] = v[(c*N+i-q[c].size())*W +: W];
      end
    return r;
  endfunction

  function automatic void model_commit(input logic [VB-1:0] v);
    for (int c = 0; c < C; c++) begin
      for (int i = 0; i < N; i++) q[c].push_back(v[(c*N+i)*W +: W]);
      for (int i = 0; i < N; i++) void'(q[c].pop_front());
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [VB-1:0] act, input logic [VB-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit vld, input bit rdy, input logic [VB-1:0] v, input string req);
    @(negedge clk);
    in_valid = vld; out_ready = rdy; din = v;
    #1;
    // R1 handshake mirror
    check(in_ready == rdy && out_valid == vld, "R1", {in_ready, out_valid}, {rdy, vld});
    if (vld) check(dout == model_out(v), req, dout, model_out(v));
    @(posedge clk);
    if (vld && rdy) model_commit(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  function automatic logic [VB-1:0] seq_vec(input int base);
    logic [VB-1:0] r;
    for (int k = 0; k < C*N; k++) r[k*W +: W] = W'(base + k);
    return r;
  endfunction

  function automatic logic [VB-1:0] rnd_vec();
    logic [VB-1:0] r;
    for (int k = 0; k < C*N; k++) r[k*W +: W] = W'($urandom);
    return r;
  endfunction

  function automatic logic [VB-1:0] pack6(input int a, b, c, d, e, f);
    logic [VB-1:0] r;
    r[0*W +: W] = W'(a); r[1*W +: W] = W'(b); r[2*W +: W] = W'(c);
    r[3*W +: W] = W'(d); r[4*W +: W] = W'(e); r[5*W +: W] = W'(f);
    return r;
  endfunction

  task automatic exact(input logic [VB-1:0] v, input logic [VB-1:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1; din = v;
    #1;
    check(dout == exp, req, dout, exp);
    @(posedge clk);
    model_commit(v);
  endtask

  initial begin
    #(CP*200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset state: no output valid without input
    #1;
    check(out_valid == 1'b0, "R1", {7'd0, out_valid}, '0);
    // R9 example, also R2 R3 R6
    exact(seq_vec(1),  pack6(1, -1, -1, 2, 3, -1),   "R9");
    exact(seq_vec(7),  pack6(7, 4, 5, 8, 9, 6),      "R9");
    exact(seq_vec(13), pack6(13, 10, 11, 14, 15, 12), "R9");
    // R5 column zero passthrough
    begin
      logic [VB-1:0] v = rnd_vec();
      @(negedge clk); in_valid = 1'b1; out_ready = 1'b1; din = v; #1;
      for (int r = 0; r < N; r++)
        check(dout[(r*C)*W +: W] == v[r*W +: W], "R5", dout[(r*C)*W +: W], v[r*W +: W]);
      @(posedge clk); model_commit(v);
    end
    // R7 stalls and gaps between transfers
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, rnd_vec(), "R7");
      step(1'b0, 1'b1, rnd_vec(), "R7");
      step(1'b1, 1'b1, rnd_vec(), "R7");
    end
    // R4 R3 R2 random stream with random handshake
    for (int k = 0; k < 300; k++)
      step(1'($urandom), 1'($urandom), rnd_vec(), "R4");
    // R8 reset mid stream, R6 refill
    do_reset();
    @(negedge clk); in_valid = 1'b1; out_ready = 1'b1; din = seq_vec(1); #1;
    check(dout == pack6(1, -1, -1, 2, 3, -1), "R8", dout, pack6(1, -1, -1, 2, 3, -1));
    @(posedge clk); model_commit(seq_vec(1));
    for (int k = 0; k < 40; k++)
      step(1'b1, 1'($urandom), rnd_vec(), "R6");
    @(negedge clk); in_valid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule